// File: doc/BRIEF.md
# Video Crop and Decimating Scaler

This block sits between a video digitizer and a capture FIFO. It receives a pixel stream qualified by a valid strobe, together with single-cycle line-start and field-start strobes, cuts a programmable rectangle out of each field and thins that rectangle down on both axes. The result leaves as a pixel stream with its own valid, start-of-line and start-of-field markers. Each axis has a 10-bit delay, a 10-bit active size and a 12-bit fixed-point shrink factor in which 256 stands for 1:1. The two most significant bits of every delay and active value share one byte, and the upper nibbles of both shrink factors share another.

Strobe conventions: `in_hsync` and `in_vsync` are one-cycle pulses that carry no pixel. A pixel offered in the same cycle as `in_hsync` is dropped. After `in_vsync`, the first `in_hsync` opens line 0. After each `in_hsync`, the first valid pixel is pixel 0. Settings written through the byte port are held in a live bank and copied into the working copy at each `in_vsync`.

Top module: `video_crop_scaler`

## Requirements
- R1: Reset clears `out_valid`, `out_sol` and `out_sof`. The working settings become horizontal delay 0, horizontal active 720, vertical delay 24, vertical active 288 and both shrink factors 256. These take effect from the first field with no register write.
- R2: Byte registers sit at these addresses. 0 holds the crop upper bits: vertical delay [9:8] in bits 7:6, vertical active [9:8] in bits 5:4, horizontal delay [9:8] in bits 3:2 and horizontal active [9:8] in bits 1:0. Address 1 holds vertical delay [7:0], 2 vertical active [7:0], 3 horizontal delay [7:0] and 4 horizontal active [7:0]. Address 5 holds vertical factor [11:8] in bits 7:4 and horizontal factor [11:8] in bits 3:0. Address 6 holds vertical factor [7:0] and 7 horizontal factor [7:0].
- R3: With horizontal factor 256, pixel p of an emitted line is output exactly when hdelay <= p < hdelay + hactive.
- R4: With vertical factor 256, line l of a field is emitted exactly when vdelay <= l < vdelay + vactive.
- R5: Number the windowed pixels of a line k = 0, 1, ... With horizontal factor S, pixel k is output exactly when floor((k+1)*256/S) > floor(k*256/S). At most one output is produced per input pixel.
- R6: Number the windowed lines of a field k = 0, 1, ... With vertical factor S, the same rule decides which lines are emitted.
- R7: A programmed factor below 256, including 0, behaves as 256.
- R8: Register writes change nothing in the field in progress. They apply from the next `in_vsync` onward.
- R9: An output pixel appears one cycle after its input pixel, with unchanged data. `out_sol` marks the first output pixel of each emitted line, and `out_sof` marks the first output pixel of a field.
- R10: An active size of 0 on either axis produces no output for the field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pixel qualifier |
| in_hsync | input | 1 | Line-start strobe |
| in_vsync | input | 1 | Field-start strobe, also loads new settings |
| in_pixel | input | PIX_W | Input pixel data |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| out_valid | output | 1 | Output pixel qualifier |
| out_sol | output | 1 | First output pixel of a line |
| out_sof | output | 1 | First output pixel of a field |
| out_pixel | output | PIX_W | Output pixel data |

## Verification
A phase accumulator that is wrong or not cleared at a line start shows up at the very next windowed pixel. The output has an extra, missing or shifted pixel whose tagged data names its line and column, so the first bad pixel is found one cycle after it enters. A fault in the window counters or in the packing of the upper bits moves the first emitted column or line, and this is visible at the first `out_sol` of the field. A working copy that follows writes immediately, instead of waiting for the field strobe, changes the pixel count of the lines that follow the write inside the same field.

// File: rtl/scaler_pkg.sv
`timescale 1ns/1ps
package scaler_pkg;
    localparam int CROP_W   = 10;
    localparam int SCALE_W  = 12;
    localparam int UNITY    = 256;
    localparam int NUM_REGS = 8;
    localparam int REG_AW   = 3;
    localparam int NUM_AX   = 2;
    localparam int AX_H     = 0;
    localparam int AX_V     = 1;

    typedef enum logic [REG_AW-1:0] {
        REG_CROP_HI  = 3'd0,
        REG_VDLY_LO  = 3'd1,
        REG_VACT_LO  = 3'd2,
        REG_HDLY_LO  = 3'd3,
        REG_HACT_LO  = 3'd4,
        REG_SCALE_HI = 3'd5,
        REG_VSCL_LO  = 3'd6,
        REG_HSCL_LO  = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic [CROP_W-1:0]  delay;
        logic [CROP_W-1:0]  active;
        logic [SCALE_W-1:0] scale;
    } axis_cfg_t;

    function automatic logic [SCALE_W-1:0] clamp_scale(input logic [SCALE_W-1:0] s);
        return (s < SCALE_W'(UNITY)) ? SCALE_W'(UNITY) : s;
    endfunction
endpackage

// File: rtl/scaler_regs.sv
`timescale 1ns/1ps
module scaler_regs
    import scaler_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              load,
    output axis_cfg_t         cfg_h,
    output axis_cfg_t         cfg_v
);
    localparam logic [7:0] RST_VAL [NUM_REGS] = '{
        8'h12, 8'h18, 8'h20, 8'h00, 8'hD0, 8'h11, 8'h00, 8'h00
    };

    logic [7:0] bank [NUM_REGS];
    axis_cfg_t  live_h, live_v;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_REGS; i++) bank[i] <= RST_VAL[i];
        end else if (wr_en) begin
            bank[wr_addr] <= wr_data;
        end
    end

    always_comb begin
        live_v.delay  = {bank[REG_CROP_HI][7:6], bank[REG_VDLY_LO]};
        live_v.active = {bank[REG_CROP_HI][5:4], bank[REG_VACT_LO]};
        live_v.scale  = {bank[REG_SCALE_HI][7:4], bank[REG_VSCL_LO]};
        live_h.delay  = {bank[REG_CROP_HI][3:2], bank[REG_HDLY_LO]};
        live_h.active = {bank[REG_CROP_HI][1:0], bank[REG_HACT_LO]};
        live_h.scale  = {bank[REG_SCALE_HI][3:0], bank[REG_HSCL_LO]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_h <= '{delay: CROP_W'(0),  active: CROP_W'(720), scale: SCALE_W'(UNITY)};
            cfg_v <= '{delay: CROP_W'(24), active: CROP_W'(288), scale: SCALE_W'(UNITY)};
        end else if (load) begin
            cfg_h <= '{delay: live_h.delay, active: live_h.active, scale: clamp_scale(live_h.scale)};
            cfg_v <= '{delay: live_v.delay, active: live_v.active, scale: clamp_scale(live_v.scale)};
        end
    end
endmodule

// File: rtl/scaler_axis.sv
`timescale 1ns/1ps
module scaler_axis
    import scaler_pkg::*;
#(
    parameter int IDX_W = CROP_W + 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      restart,
    input  logic      adv,
    input  axis_cfg_t cfg,
    output logic      take
);
    localparam int ACC_W = SCALE_W + 1;

    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] win_lo, win_hi;
    logic [ACC_W-1:0] acc, acc_sum;
    logic             in_win, hit;

    always_comb begin
        win_lo  = IDX_W'(cfg.delay);
        win_hi  = IDX_W'(cfg.delay) + IDX_W'(cfg.active);
        in_win  = (idx >= win_lo) && (idx < win_hi);
        acc_sum = acc + ACC_W'(UNITY);
        hit     = acc_sum >= ACC_W'(cfg.scale);
        take    = adv && !restart && in_win && hit;
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            idx <= '0;
            acc <= '0;
        end else if (adv) begin
            if (idx != '1) idx <= idx + 1'b1;
            if (in_win) acc <= hit ? (acc_sum - ACC_W'(cfg.scale)) : acc_sum;
        end
    end
endmodule

// File: rtl/video_crop_scaler.sv
`timescale 1ns/1ps
module video_crop_scaler
    import scaler_pkg::*;
#(
    parameter int PIX_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_hsync,
    input  logic             in_vsync,
    input  logic [PIX_W-1:0] in_pixel,
    input  logic             reg_wr,
    input  logic [2:0]       reg_addr,
    input  logic [7:0]       reg_wdata,
    output logic             out_valid,
    output logic             out_sol,
    output logic             out_sof,
    output logic [PIX_W-1:0] out_pixel
);
    localparam int IDX_W = CROP_W + 2;

    axis_cfg_t         cfg [NUM_AX];
    logic [NUM_AX-1:0] ax_restart, ax_adv, ax_take;
    logic              line_on, first_line, first_field, emit;

    scaler_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (reg_wr),
        .wr_addr (reg_addr),
        .wr_data (reg_wdata),
        .load    (in_vsync),
        .cfg_h   (cfg[AX_H]),
        .cfg_v   (cfg[AX_V])
    );

    assign ax_restart[AX_H] = in_hsync;
    assign ax_adv[AX_H]     = in_valid;
    assign ax_restart[AX_V] = in_vsync;
    assign ax_adv[AX_V]     = in_hsync;

    generate
        for (genvar a = 0; a < NUM_AX; a++) begin : g_axis
            scaler_axis #(.IDX_W(IDX_W)) u_axis (
                .clk     (clk),
                .rst     (rst),
                .restart (ax_restart[a]),
                .adv     (ax_adv[a]),
                .cfg     (cfg[a]),
                .take    (ax_take[a])
            );
        end
    endgenerate

    assign emit = ax_take[AX_H] && line_on;

    always_ff @(posedge clk) begin
        if (rst) begin
            line_on     <= 1'b0;
            first_line  <= 1'b0;
            first_field <= 1'b0;
            out_valid   <= 1'b0;
            out_sol     <= 1'b0;
            out_sof     <= 1'b0;
            out_pixel   <= '0;
        end else begin
            if (emit) begin
                first_line  <= 1'b0;
                first_field <= 1'b0;
                out_pixel   <= in_pixel;
            end
            if (in_vsync) begin
                line_on     <= 1'b0;
                first_field <= 1'b1;
            end else if (in_hsync) begin
                line_on    <= ax_take[AX_V];
                first_line <= 1'b1;
            end
            out_valid <= emit;
            out_sol   <= emit && first_line;
            out_sof   <= emit && first_field;
        end
    end
endmodule

// File: rtl/scaler_checker.sv
`timescale 1ns/1ps
module scaler_checker #(
    parameter int PIX_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_hsync,
    input logic             in_vsync,
    input logic [PIX_W-1:0] in_pixel,
    input logic             out_valid,
    input logic             out_sol,
    input logic             out_sof,
    input logic [PIX_W-1:0] out_pixel
);
    logic sof_seen;

    always_ff @(posedge clk) begin
        if (rst) sof_seen <= 1'b0;
        else if (in_vsync) sof_seen <= 1'b0;
        else if (out_sof) sof_seen <= 1'b1;
    end

    AST_SOL_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst) out_sol |-> out_valid); // R9
    AST_SOF_NEEDS_SOL: assert property (@(posedge clk) disable iff (rst) out_sof |-> out_sol); // R9
    AST_ONE_OUT_PER_IN: assert property (@(posedge clk) disable iff (rst) out_valid |-> ($past(in_valid) && !$past(in_hsync))); // R5
    AST_PIXEL_UNCHANGED: assert property (@(posedge clk) disable iff (rst) out_valid |-> (out_pixel == $past(in_pixel))); // R9
    AST_SINGLE_SOF: assert property (@(posedge clk) disable iff (rst) out_sof |-> !sof_seen); // R9
endmodule

bind video_crop_scaler scaler_checker #(.PIX_W(PIX_W)) u_check (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_hsync  (in_hsync),
    .in_vsync  (in_vsync),
    .in_pixel  (in_pixel),
    .out_valid (out_valid),
    .out_sol   (out_sol),
    .out_sof   (out_sof),
    .out_pixel (out_pixel)
);

// File: tb/video_crop_scaler_test.sv
`timescale 1ns/1ps
module video_crop_scaler_test;
    localparam int PIX_W    = 16;
    localparam int WATCHDOG = 150000;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_valid = 1'b0, in_hsync = 1'b0, in_vsync = 1'b0;
    logic [PIX_W-1:0] in_pixel = '0;
    logic             reg_wr = 1'b0;
    logic [2:0]       reg_addr = '0;
    logic [7:0]       reg_wdata = '0;
    logic             out_valid, out_sol, out_sof;
    logic [PIX_W-1:0] out_pixel;

    always #2.5 clk = ~clk;

    video_crop_scaler #(.PIX_W(PIX_W)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_hsync(in_hsync),
        .in_vsync(in_vsync), .in_pixel(in_pixel), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .out_valid(out_valid),
        .out_sol(out_sol), .out_sof(out_sof), .out_pixel(out_pixel)
    );

    int checks = 0;
    int errors = 0;
    // pending (written) and active (field in progress) settings
    int p_hd = 0, p_ha = 720, p_vd = 24, p_va = 288, p_hs = 256, p_vs = 256;
    int a_hd, a_ha, a_vd, a_va, a_hs, a_vs;

    logic [PIX_W-1:0] q_pix [$];
    bit               q_sol [$];
    bit               q_sof [$];
    string            q_tag [$];
    string            cur_tag = "R1";

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int eff(input int s);
        return (s < 256) ? 256 : s;
    endfunction

    function automatic bit picks(input int k, input int s);
        return ((k + 1) * 256) / s > (k * 256) / s;
    endfunction

    task automatic wr_reg(input int a, input int d);
        reg_wr    = 1'b1;
        reg_addr  = 3'(a);
        reg_wdata = 8'(d);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    // R2: packs each value into its byte registers
    task automatic set_cfg(input int hd, input int ha, input int vd, input int va,
                           input int hs, input int vs);
        p_hd = hd; p_ha = ha; p_vd = vd; p_va = va; p_hs = hs; p_vs = vs;
        wr_reg(0, (((vd >> 8) & 3) << 6) | (((va >> 8) & 3) << 4) |
                  (((hd >> 8) & 3) << 2) | ((ha >> 8) & 3));
        wr_reg(1, vd & 255);
        wr_reg(2, va & 255);
        wr_reg(3, hd & 255);
        wr_reg(4, ha & 255);
        wr_reg(5, (((vs >> 8) & 15) << 4) | ((hs >> 8) & 15));
        wr_reg(6, vs & 255);
        wr_reg(7, hs & 255);
    endtask

    // driver: pushes the expected items, then plays one field
    task automatic run_field(input int nl, input int np, input string tag,
                             input int mid_ha = -1);
        bit first_f, first_l;
        a_hd = p_hd; a_ha = p_ha; a_vd = p_vd; a_va = p_va;
        a_hs = eff(p_hs); a_vs = eff(p_vs);
        first_f = 1'b1;
        for (int l = 0; l < nl; l++) begin
            if (l >= a_vd && l < a_vd + a_va && picks(l - a_vd, a_vs)) begin
                first_l = 1'b1;
                for (int p = 0; p < np; p++) begin
                    if (p >= a_hd && p < a_hd + a_ha && picks(p - a_hd, a_hs)) begin
                        q_pix.push_back(PIX_W'(((l % 256) * 256) + (p % 256)));
                        q_sol.push_back(first_l);
                        q_sof.push_back(first_f);
                        q_tag.push_back(tag);
                        first_l = 1'b0;
                        first_f = 1'b0;
                    end
                end
            end
        end
        cur_tag = tag;
        in_vsync = 1'b1; @(negedge clk);
        in_vsync = 1'b0; repeat (2) @(negedge clk);
        for (int l = 0; l < nl; l++) begin
            in_hsync = 1'b1; @(negedge clk);
            in_hsync = 1'b0; @(negedge clk);
            for (int p = 0; p < np; p++) begin
                in_valid = 1'b1;
                in_pixel = PIX_W'(((l % 256) * 256) + (p % 256));
                @(negedge clk);
            end
            in_valid = 1'b0;
            repeat (2) @(negedge clk);
            if (l == 1 && mid_ha >= 0) begin
                wr_reg(4, mid_ha & 255);
                p_ha = (p_ha & ~255) | (mid_ha & 255);
            end
        end
        repeat (3) @(negedge clk);
        check(q_pix.size() == 0, tag, "expected outputs left unseen", q_pix.size(), 0);
        q_pix.delete(); q_sol.delete(); q_sof.delete(); q_tag.delete();
    endtask

    // monitor: pops and compares every produced pixel
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (q_pix.size() == 0) begin
                check(1'b0, cur_tag, "unexpected output pixel", int'(out_pixel), -1);
            end else begin
                logic [PIX_W-1:0] ep;
                bit es, ef;
                string et;
                ep = q_pix.pop_front();
                es = q_sol.pop_front();
                ef = q_sof.pop_front();
                et = q_tag.pop_front();
                check(out_pixel == ep, et, "output pixel", int'(out_pixel), int'(ep));
                check({out_sol, out_sof} == {es, ef}, "R9", "sol/sof markers",
                      int'({out_sol, out_sof}), int'({es, ef}));
            end
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check({out_valid, out_sol, out_sof} == 3'b000, "R1", "outputs in reset",
              int'({out_valid, out_sol, out_sof}), 0);
        rst = 1'b0;
        @(negedge clk);
        check({out_valid, out_sol, out_sof} == 3'b000, "R1", "outputs after reset",
              int'({out_valid, out_sol, out_sof}), 0);
        // R1: defaults, lines 24 and 25 pass whole
        run_field(26, 8, "R1");
        // R3, R4: plain window
        set_cfg(2, 5, 1, 3, 256, 256);
        run_field(6, 10, "R3,R4");
        // R5: horizontal shrink by 2 and by 1.5
        set_cfg(1, 9, 0, 2, 512, 256);
        run_field(3, 12, "R5");
        set_cfg(0, 11, 0, 1, 384, 256);
        run_field(2, 12, "R5");
        // R6: vertical shrink by 2.5
        set_cfg(1, 3, 0, 7, 256, 640);
        run_field(8, 5, "R6");
        // R7: factors below unity clamp
        set_cfg(0, 4, 0, 2, 100, 0);
        run_field(3, 5, "R7");
        // R2: upper bits of delay, active and factor
        set_cfg(258, 260, 0, 2, 256, 256);
        run_field(2, 520, "R2");
        set_cfg(0, 10, 257, 1, 768, 256);
        run_field(259, 12, "R2");
        // R8: write mid-field, applies at next field only
        set_cfg(0, 6, 0, 4, 256, 256);
        run_field(4, 8, "R8", 2);
        run_field(2, 8, "R8");
        // R10: zero active size on either axis
        set_cfg(0, 0, 0, 3, 256, 256);
        run_field(3, 6, "R10");
        set_cfg(0, 5, 0, 0, 256, 256);
        run_field(3, 6, "R10");
        finish_run();
    end
endmodule